// File: doc/BRIEF.md
# Quad SPI Continuous Word-Read Controller

This block is the host side of a quad-lane serial flash read path. A client puts a byte address, a byte count and a "keep" flag on the request port and pulses start. The controller lowers chip select and runs the serial clock at half the system clock rate. It sends the read opcode on one lane, then the address and a mode byte on all four lanes. It releases the lanes for two turnaround clocks and then collects nibbles from the device, handing one byte at a time to the client with a one-cycle valid strobe.

The controller keeps one bit that records which mode byte it sent last. When that byte armed continuous reading, the next transaction leaves out the 8-clock opcode phase and starts directly with the address. The keep flag of each request chooses the mode byte, and so decides whether the following read may also skip the opcode. The design assumes the device's quad-enable bit is already set, and that the client ends continuous reading (a request with keep low) before anything else talks to the device.

Top module: `qspi_wordrd_ctrl`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, all four lane output enables are low, busy is low and the armed bit is low.
- R2: When the armed bit is low, a transaction begins with opcode E7h sent most significant bit first on lane 0 over 8 serial clocks, with only lane 0 enabled (`io_oe_o` = 0001b).
- R3: The address is sent as 6 nibbles, one per serial clock, most significant nibble first, with lane 3 carrying the nibble's bit 3 and all four lanes enabled. Address bit 0 is always sent as 0, even when the request address is odd.
- R4: Two mode nibbles follow the address with all lanes enabled. The first is Ah when the request's keep flag is 1 and 0h when it is 0. The second is 0h.
- R5: Exactly two turnaround clocks follow the mode byte, and all output enables are low from the first turnaround clock to the end of the data phase. The output enable pattern is only ever 0000b, 0001b or 1111b.
- R6: Data nibbles are sampled on each rising serial clock edge, high nibble first. Each pair of nibbles gives one byte on `rd_data_o` with a one-cycle `rd_valid_o`. Exactly the requested count of bytes is delivered, from consecutive addresses starting at the even address that was sent.
- R7: The armed bit equals the keep flag of the last transaction that sent a mode byte. When it is set, the next transaction omits the opcode and starts with the address. The armed bit does not change while the block is idle.
- R8: Busy rises in the cycle after an accepted start and stays high until chip select has been high for the gap time after the last data clock. Chip select is high whenever busy is low. A start pulse while busy is ignored. The strobe for the last byte falls in the first cycle with chip select high.
- R9: A start with a byte count of zero is ignored: busy stays low and chip select does not fall.
- R10: The serial clock is low whenever chip select is high and is never high for two consecutive system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_addr_i | input | ADDR_W | Byte address of the read (bit 0 forced to 0) |
| req_len_i | input | LEN_W | Number of bytes to read, zero ignored |
| req_keep_i | input | 1 | 1: send mode Ah and stay armed, 0: send 0h and leave |
| req_start_i | input | 1 | Start pulse, accepted only while idle |
| busy_o | output | 1 | Transaction in progress |
| rd_valid_o | output | 1 | One-cycle strobe for `rd_data_o` |
| rd_data_o | output | 8 | Received byte |
| cont_armed_o | output | 1 | Last mode byte sent armed continuous reading |
| sck_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| io_o | output | 4 | Lane output values |
| io_oe_o | output | 4 | Lane output enables, one per lane |
| io_i | input | 4 | Lane input values |

## Verification
The valid strobe for the final byte and the rise of chip select fall in the same system cycle. The bench sweeps byte counts one to six and a long read over addresses that include odd values and the top of the address space. For every read it counts the cycles in which the strobe and a high chip select occur together, and requires exactly one. It also requires the byte count and every byte value to match. The keep flag follows a sequence that contains all four transitions of the armed bit, so opcode-skip and opcode-send transactions both pass through this end-of-read cycle. Some reads also receive a second start pulse mid-transfer, which must leave the transfer unchanged.

// File: rtl/qspi_wordrd_pkg.sv
`timescale 1ns/1ps
package qspi_wordrd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_MODE, ST_DUMMY, ST_DATA, ST_GAP
  } st_e;

  localparam logic [7:0] RD_OPC     = 8'hE7;
  localparam int         CMD_CLKS   = 8;
  localparam int         MODE_CLKS  = 2;
  localparam int         DUMMY_CLKS = 2;
  localparam logic [3:0] MODE_KEEP  = 4'hA;
  localparam logic [3:0] MODE_EXIT  = 4'h0;
endpackage

// File: rtl/qspi_wordrd_seq.sv
`timescale 1ns/1ps
module qspi_wordrd_seq
  import qspi_wordrd_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int LEN_W   = 8,
  parameter int CNT_W   = 12,
  parameter int GAP_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              keep_i,
  output st_e               state_o,
  output logic              ph_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              keep_o,
  output logic              armed_o
);
  localparam int NIB_N = ADDR_W / 4;

  st_e               state_q, next_st;
  logic              ph_q, keep_q, armed_q;
  logic [CNT_W-1:0]  cnt_q, last_cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;

  always_comb begin
    last_cnt = '0;
    next_st  = ST_IDLE;
    unique case (state_q)
      ST_CMD:   begin last_cnt = CNT_W'(CMD_CLKS - 1);   next_st = ST_ADDR;  end
      ST_ADDR:  begin last_cnt = CNT_W'(NIB_N - 1);      next_st = ST_MODE;  end
      ST_MODE:  begin last_cnt = CNT_W'(MODE_CLKS - 1);  next_st = ST_DUMMY; end
      ST_DUMMY: begin last_cnt = CNT_W'(DUMMY_CLKS - 1); next_st = ST_DATA;  end
      ST_DATA:  begin last_cnt = CNT_W'({len_q, 1'b0}) - CNT_W'(1); next_st = ST_GAP; end
      ST_GAP:   begin last_cnt = CNT_W'(GAP_CYC - 1);    next_st = ST_IDLE;  end
      default:  begin last_cnt = '0;                     next_st = ST_IDLE;  end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ph_q    <= 1'b0;
      cnt_q   <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      keep_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          ph_q  <= 1'b0;
          cnt_q <= '0;
          if (start_i && (len_i != '0)) begin
            addr_q  <= {addr_i[ADDR_W-1:1], 1'b0};
            len_q   <= len_i;
            keep_q  <= keep_i;
            state_q <= armed_q ? ST_ADDR : ST_CMD;
          end
        end
        ST_GAP: begin
          if (cnt_q == last_cnt) begin
            cnt_q   <= '0;
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: begin
          ph_q <= ~ph_q;
          if (ph_q) begin
            if (cnt_q == last_cnt) begin
              cnt_q   <= '0;
              state_q <= next_st;
              // mode byte fully sent: it now governs the next transaction
              if (state_q == ST_MODE) armed_q <= keep_q;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
      endcase
    end
  end

  assign state_o = state_q;
  assign ph_o    = ph_q;
  assign cnt_o   = cnt_q;
  assign addr_o  = addr_q;
  assign keep_o  = keep_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/qspi_wordrd_pins.sv
`timescale 1ns/1ps
module qspi_wordrd_pins
  import qspi_wordrd_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 12
) (
  input  st_e               state_i,
  input  logic              ph_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              keep_i,
  output logic              sck_o,
  output logic              cs_no,
  output logic [3:0]        io_o,
  output logic [3:0]        io_oe_o
);
  logic active;

  always_comb begin
    unique case (state_i)
      ST_CMD, ST_ADDR, ST_MODE, ST_DUMMY, ST_DATA: active = 1'b1;
      default:                                     active = 1'b0;
    endcase
  end

  assign sck_o = active & ph_i;
  assign cs_no = ~active;

  // outputs depend on counter only, so they move on the falling sck half
  always_comb begin
    io_o    = 4'h0;
    io_oe_o = 4'h0;
    unique case (state_i)
      ST_CMD: begin
        io_o    = {3'b000, 1'(RD_OPC >> (CMD_CLKS - 1 - int'(cnt_i)))};
        io_oe_o = 4'b0001;
      end
      ST_ADDR: begin
        io_o    = 4'(addr_i >> (ADDR_W - 4 - 4 * int'(cnt_i)));
        io_oe_o = 4'b1111;
      end
      ST_MODE: begin
        io_o    = (cnt_i == '0) ? (keep_i ? MODE_KEEP : MODE_EXIT) : 4'h0;
        io_oe_o = 4'b1111;
      end
      default: begin
        io_o    = 4'h0;
        io_oe_o = 4'b0000;
      end
    endcase
  end
endmodule

// File: rtl/qspi_wordrd_rx.sv
`timescale 1ns/1ps
module qspi_wordrd_rx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       smp_i,
  input  logic       odd_i,
  input  logic [3:0] io_i,
  output logic [7:0] data_o,
  output logic       valid_o
);
  logic [3:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= 4'h0;
      data_o  <= 8'h00;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (smp_i) begin
        if (!odd_i) begin
          hi_q <= io_i;
        end else begin
          data_o  <= {hi_q, io_i};
          valid_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/qspi_wordrd_ctrl.sv
`timescale 1ns/1ps
module qspi_wordrd_ctrl
  import qspi_wordrd_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int LEN_W   = 8,
  parameter int GAP_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              req_keep_i,
  input  logic              req_start_i,
  output logic              busy_o,
  output logic              rd_valid_o,
  output logic [7:0]        rd_data_o,
  output logic              cont_armed_o,
  output logic              sck_o,
  output logic              cs_no,
  output logic [3:0]        io_o,
  output logic [3:0]        io_oe_o,
  input  logic [3:0]        io_i
);
  localparam int CNT_W = LEN_W + 4;

  st_e               state;
  logic              ph, keep;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr;

  qspi_wordrd_seq #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .CNT_W  (CNT_W),
    .GAP_CYC(GAP_CYC)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(req_start_i),
    .addr_i (req_addr_i),
    .len_i  (req_len_i),
    .keep_i (req_keep_i),
    .state_o(state),
    .ph_o   (ph),
    .cnt_o  (cnt),
    .addr_o (addr),
    .keep_o (keep),
    .armed_o(cont_armed_o)
  );

  qspi_wordrd_pins #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
  ) u_pins (
    .state_i(state),
    .ph_i   (ph),
    .cnt_i  (cnt),
    .addr_i (addr),
    .keep_i (keep),
    .sck_o  (sck_o),
    .cs_no  (cs_no),
    .io_o   (io_o),
    .io_oe_o(io_oe_o)
  );

  qspi_wordrd_rx u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .smp_i  ((state == ST_DATA) && ph),
    .odd_i  (cnt[0]),
    .io_i   (io_i),
    .data_o (rd_data_o),
    .valid_o(rd_valid_o)
  );

  assign busy_o = (state != ST_IDLE);
endmodule

// File: rtl/qspi_wordrd_chk.sv
`timescale 1ns/1ps
module qspi_wordrd_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_start_i,
  input logic [LEN_W-1:0] req_len_i,
  input logic             busy_o,
  input logic             cs_no,
  input logic             sck_o,
  input logic             rd_valid_o,
  input logic             cont_armed_o,
  input logic [3:0]       io_oe_o
);
  assert_cs_high_sck_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o);

  assert_sck_half_rate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |=> !sck_o);

  assert_cs_high_lanes_free_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> (io_oe_o == 4'b0000));

  assert_oe_pattern_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_oe_o == 4'b0000) || (io_oe_o == 4'b0001) || (io_oe_o == 4'b1111));

  assert_strobe_lanes_free_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (io_oe_o == 4'b0000));

  assert_strobe_in_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> busy_o);

  assert_idle_cs_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_no);

  assert_zero_len_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_start_i && (req_len_i == '0)) |=> !busy_o);

  assert_armed_stable_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(cont_armed_o));
endmodule

bind qspi_wordrd_ctrl qspi_wordrd_chk #(.LEN_W(LEN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_start_i (req_start_i),
  .req_len_i   (req_len_i),
  .busy_o      (busy_o),
  .cs_no       (cs_no),
  .sck_o       (sck_o),
  .rd_valid_o  (rd_valid_o),
  .cont_armed_o(cont_armed_o),
  .io_oe_o     (io_oe_o)
);

// File: tb/qspi_wordrd_ctrl_tb_top.sv
`timescale 1ns/1ps
module qspi_wordrd_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] req_addr = '0;
  logic [7:0]  req_len = '0;
  logic        req_keep = 1'b0;
  logic        req_start = 1'b0;
  logic        busy_o, rd_valid_o, cont_armed_o, sck_o, cs_no;
  logic [7:0]  rd_data_o;
  logic [3:0]  io_o, io_oe_o;
  logic [3:0]  io_i = 4'h0;

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 1'b0;
  bit exp_armed = 1'b0;

  always #2.5 clk = ~clk;

  qspi_wordrd_ctrl dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_addr_i  (req_addr),
    .req_len_i   (req_len),
    .req_keep_i  (req_keep),
    .req_start_i (req_start),
    .busy_o      (busy_o),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o),
    .cont_armed_o(cont_armed_o),
    .sck_o       (sck_o),
    .cs_no       (cs_no),
    .io_o        (io_o),
    .io_oe_o     (io_oe_o),
    .io_i        (io_i)
  );

  function automatic logic [7:0] pat(input logic [23:0] a);
    return 8'((a[7:0] * 8'd29 + a[15:8]) ^ 8'h96);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // flash device model
  int          m_edge = 0;
  int          m_oe_bad = 0;
  int          cs_falls = 0;
  bit          m_skip = 1'b0;
  bit          m_armed = 1'b0;
  logic [7:0]  m_op = '0;
  logic [7:0]  m_mode = '0;
  logic [23:0] m_addr = '0;

  always @(negedge cs_no) begin
    m_edge   = 0;
    m_skip   = m_armed;
    m_oe_bad = 0;
    m_op     = '0;
    m_mode   = '0;
    m_addr   = '0;
    cs_falls++;
  end

  always @(posedge cs_no) m_armed = (m_mode[7:4] == 4'hA);

  always @(posedge sck_o) begin
    if (!cs_no) begin
      int p;
      p = m_skip ? m_edge + 8 : m_edge;
      if (p < 8) begin
        m_op = {m_op[6:0], io_o[0]};
        if (io_oe_o != 4'b0001) m_oe_bad++;
      end else if (p < 14) begin
        m_addr = {m_addr[19:0], io_o};
        if (io_oe_o != 4'b1111) m_oe_bad++;
      end else if (p < 16) begin
        m_mode = {m_mode[3:0], io_o};
        if (io_oe_o != 4'b1111) m_oe_bad++;
      end else if (io_oe_o != 4'b0000) begin
        m_oe_bad++;
      end
      m_edge++;
    end
  end

  always @(negedge sck_o) begin
    if (!cs_no) begin
      int d;
      logic [7:0] b;
      d = (m_skip ? m_edge + 8 : m_edge) - 18;
      if (d >= 0) begin
        b = pat(m_addr + 24'(d / 2));
        io_i = (d % 2 == 0) ? b[7:4] : b[3:0];
      end
    end
  end

  // byte capture, sampled away from the active edge
  logic [7:0] rx_buf [0:255];
  int rx_n = 0;
  int ov_n = 0;

  always @(negedge clk) begin
    if (rd_valid_o) begin
      if (rx_n < 256) rx_buf[rx_n] = rd_data_o;
      rx_n++;
      if (cs_no) ov_n++;
    end
  end

  task automatic do_read(input logic [23:0] a, input int len, input bit keep, input bit poke);
    bit          exp_skip;
    logic [23:0] ea;
    int          bad;
    int          first_bad;
    exp_skip = exp_armed;
    ea = {a[23:1], 1'b0};
    rx_n = 0;
    ov_n = 0;
    @(negedge clk);
    req_addr = a; req_len = 8'(len); req_keep = keep; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    chk(busy_o === 1'b1, "R8", "busy after start", 32'(busy_o), 32'd1);
    if (poke) begin
      repeat (6) @(negedge clk);
      req_addr = ~a; req_len = 8'd3; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
    end
    while (busy_o) @(negedge clk);
    chk(m_skip == exp_skip, "R7", "opcode skipped", 32'(m_skip), 32'(exp_skip));
    if (!exp_skip) chk(m_op == 8'hE7, "R2", "opcode", 32'(m_op), 32'hE7);
    chk(m_addr == ea, "R3", "address", 32'(m_addr), 32'(ea));
    chk(m_mode == {(keep ? 4'hA : 4'h0), 4'h0}, "R4", "mode byte", 32'(m_mode),
        32'({(keep ? 4'hA : 4'h0), 4'h0}));
    chk(m_edge == (exp_skip ? 0 : 8) + 10 + 2 * len, "R5", "sck edges", 32'(m_edge),
        32'((exp_skip ? 0 : 8) + 10 + 2 * len));
    chk(m_oe_bad == 0, "R5", "lane enable errors", 32'(m_oe_bad), 32'd0);
    chk(rx_n == len, "R6", "byte count", 32'(rx_n), 32'(len));
    bad = 0;
    first_bad = -1;
    for (int i = 0; i < len && i < 256; i++) begin
      if (rx_buf[i] !== pat(ea + 24'(i))) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
    end
    chk(bad == 0, "R6", "bad data bytes", 32'(bad), 32'd0);
    if (first_bad >= 0)
      chk(1'b0, "R6", "first bad byte", 32'(rx_buf[first_bad]), 32'(pat(ea + 24'(first_bad))));
    chk(ov_n == 1, "R8", "last strobe with cs high", 32'(ov_n), 32'd1);
    chk(cont_armed_o == keep, "R7", "armed bit", 32'(cont_armed_o), 32'(keep));
    exp_armed = keep;
  endtask

  task automatic zero_len();
    int falls0;
    bit arm0;
    falls0 = cs_falls;
    arm0 = cont_armed_o;
    @(negedge clk);
    req_len = 8'd0; req_addr = 24'h000100; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    chk(busy_o == 1'b0, "R9", "busy after zero-length start", 32'(busy_o), 32'd0);
    repeat (4) @(negedge clk);
    chk(cs_falls == falls0, "R9", "cs falls", 32'(cs_falls), 32'(falls0));
    chk(cont_armed_o == arm0, "R9", "armed unchanged", 32'(cont_armed_o), 32'(arm0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_no == 1'b1, "R1", "cs in reset", 32'(cs_no), 32'd1);
    chk(sck_o == 1'b0, "R10", "sck in reset", 32'(sck_o), 32'd0);
    chk(io_oe_o == 4'h0, "R1", "oe in reset", 32'(io_oe_o), 32'd0);
    chk(busy_o == 1'b0, "R1", "busy in reset", 32'(busy_o), 32'd0);
    chk(cont_armed_o == 1'b0, "R1", "armed in reset", 32'(cont_armed_o), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_no == 1'b1 && sck_o == 1'b0, "R10", "idle pins", 32'({cs_no, sck_o}), 32'b10);

    for (int i = 0; i < 72; i++) begin
      do_read(24'(i * 32'h010F3B + 32'h101), 1 + i % 6, 1'(((i * 5) >> 1) & 1), (i % 7) == 3);
    end

    zero_len();
    do_read(24'h123457, 2, 1'b1, 1'b0);
    zero_len();
    do_read(24'hFFFFFF, 40, 1'b0, 1'b0);
    do_read(24'h000001, 3, 1'b1, 1'b1);
    do_read(24'h000001, 1, 1'b0, 1'b0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end
endmodule